// File: doc/BRIEF.md
# ADC Conversion Control

This block holds the control and status logic that sits between a register bus and an 8-channel successive-approximation converter. Software reads and writes one 8-bit control/status register and can read a second register that holds the upper part of the 10-bit result. A conversion can begin in two ways. Software can write a 1 to the start bit, or, if the external trigger is enabled, a rising edge on an asynchronous trigger pin can begin it. The block tracks the busy and done states, raises an interrupt request when a result is waiting, and latches the 10-bit result.

The analog converter is modelled by a handshake of fixed length. The block sends a one-cycle launch pulse together with a 3-bit channel select, and it samples the converter's 10-bit result on the last cycle of the conversion window. The interlocks are strict. Only hardware clears the busy bit. Only hardware sets the done flag. The channel field accepts writes only while the block is fully idle.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0 and `irq` and `conv_start` are 0.
- R2: A write to the control register (address 0) with bit 3 set, while busy and done are both 0, begins a conversion. `conv_start` pulses for one cycle and busy (bit 3) reads 1 from the cycle after the write.
- R3: Busy reads 1 for exactly CONV_CYCLES cycles. In the cycle it drops, the done flag (bit 4) rises, and the result is taken from `conv_result` on that last busy cycle.
- R4: Control bits 7:6 read result bits 1:0. Address 1 reads result bits 9:2.
- R5: Bit 5 enables the external trigger. When it is 1, a rising edge on `ext_start` begins a conversion, after a synchronizer of SYNC_STAGES flops and one edge-detect flop. When it is 0, the pin has no effect.
- R6: A start request from software or from the pin is ignored while busy, and the conversion window is not restarted.
- R7: A start requires the done flag to be 0. A write with both bit 4 and bit 3 set while done is 1 starts nothing.
- R8: A single write that clears bit 4 and sets bit 3 while done is 1 begins a new conversion on the unchanged channel.
- R9: Channel bits 2:0 (bit 2 is the MSB) take a write only when done and busy are both 0. `conv_chan` always shows the current field.
- R10: Software cannot clear busy by writing bit 3 as 0, and cannot set done by writing bit 4 as 1. Writing bit 4 as 0 clears done.
- R11: `irq` is 1 exactly when the done flag is 1 and `irq_enable` is 1.
- R12: If a write that clears done lands in the cycle a conversion completes, the completion wins and done reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = result high |
| bus_wdata | input | 6 | Write data for the writable control bits 5:0 |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_start | input | 1 | Asynchronous external trigger |
| irq_enable | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle launch pulse to the converter |
| conv_chan | output | 3 | Channel select to the multiplexer |
| conv_result | input | 10 | Converter result |

## Verification
Two events can fall in the same clock cycle: a conversion completing and a software write that clears the done flag. The bench places the clearing write exactly CONV_CYCLES cycles after the start write, so the write lands on the completion edge, and it expects done to stay set. A second coincidence happens when a software start and a synchronized pin edge arrive in the same cycle, or when either arrives during a conversion. A behavioural model judges all of these on every clock, and it expects exactly one launch or none.

// File: rtl/adc_ctrl_pkg.sv
// Shared widths and the read-side view of the control/status register.
// Assumes an 8-bit register bus and a 10-bit converter.
package adc_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int RES_W  = 10;
    localparam int CH_W   = 3;

    // Bit positions that software decodes in the control/status register
    localparam int BIT_EXT   = 5;
    localparam int BIT_DONE  = 4;
    localparam int BIT_START = 3;

    typedef struct packed {
        logic [1:0]      res_lo;
        logic            ext_en;
        logic            done;
        logic            busy;
        logic [CH_W-1:0] chan;
    } ctrl_view_t;
endpackage

// File: rtl/adc_start_sync.sv
// Brings the asynchronous trigger pin into the clock domain and flags its rising edge.
// Assumes the pin stays high or low for at least two clock cycles at a time.
// Latency: STAGES flops, then one compare flop.
module adc_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // First stage samples the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining stages of the synchronizer.
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Delayed copy, used to detect the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/adc_conv_timer.sv
// Runs the fixed-length conversion window and latches the converter result.
// Assumes launch is only raised while not busy.
module adc_conv_timer
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [RES_W-1:0] conv_result,
    output logic             busy,
    output logic             finish,
    output logic [RES_W-1:0] result,
    output logic             conv_start
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] remain;

    assign finish = busy && (remain == '0);

    // Busy flag and countdown through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            remain <= LAST;
        end else if (finish) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end

    // Result capture on the final busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (finish) result <= conv_result;
    end

    // One-cycle launch pulse to the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= launch;
    end

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_start); // R2
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain <= LAST)); // R3
endmodule

// File: rtl/adc_conv_ctrl.sv
// Control/status register logic for an 8-channel converter: start interlocks,
// channel lock, done flag, interrupt request and the result read-out.
// Assumes a single-cycle register write strobe and a combinational read.
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [5:0]        bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_start,
    input  logic              irq_enable,
    output logic              irq,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic [RES_W-1:0]  conv_result
);
    logic             ext_en, done;
    logic [CH_W-1:0]  chan;
    logic             busy, finish, pin_rise;
    logic [RES_W-1:0] result;
    logic             ctrl_wr, done_eff, req, launch;
    ctrl_view_t       view;

    adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_start), .rise(pin_rise)
    );

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .conv_result(conv_result),
        .busy(busy), .finish(finish), .result(result), .conv_start(conv_start)
    );

    // Start decision: a clearing write counts as done=0 for the same-cycle start.
    always_comb begin
        ctrl_wr  = bus_wr && !bus_addr;
        done_eff = ctrl_wr ? (done && bus_wdata[BIT_DONE]) : done;
        req      = (ctrl_wr && bus_wdata[BIT_START]) || (pin_rise && ext_en);
        launch   = req && !busy && !done_eff;
    end

    // Trigger-enable field, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_en <= 1'b0;
        else if (ctrl_wr) ext_en <= bus_wdata[BIT_EXT];
    end

    // Done flag: set by completion (which wins), cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      done <= 1'b0;
        else if (finish) done <= 1'b1;
        else             done <= done_eff;
    end

    // Channel field, locked unless fully idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          chan <= '0;
        else if (ctrl_wr && !busy && !done)  chan <= bus_wdata[CH_W-1:0];
    end

    // Read-side assembly and outputs.
    always_comb begin
        view.res_lo = result[1:0];
        view.ext_en = ext_en;
        view.done   = done;
        view.busy   = busy;
        view.chan   = chan;
        bus_rdata   = bus_addr ? result[RES_W-1:2] : DATA_W'(view);
    end

    assign irq       = done && irq_enable;
    assign conv_chan = chan;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R3
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3
    AST_DONE_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R10
    AST_CHAN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan) |-> $past(!busy && !done)); // R9
    AST_NO_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !done); // R7
endmodule

// File: tb/adc_conv_ctrl_test.sv
module adc_conv_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_start = 1'b0, irq_enable = 1'b0, irq, conv_start;
    logic [2:0] conv_chan;
    logic [9:0] conv_result = 10'h155;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit armed = 0;

    adc_conv_ctrl #(.CONV_CYCLES(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_start(ext_start),
        .irq_enable(irq_enable), .irq(irq), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_result(conv_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    bit       m_ext_en, m_done, m_busy, m_start;
    int       m_left;
    bit [2:0] m_chan;
    bit [9:0] m_res;
    bit       p0, p1, p2;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update on every rising edge.
    always @(posedge clk) begin
        bit wr0, d_eff, go, fin, edge_seen;
        if (!rst_n) begin
            m_ext_en = 0; m_done = 0; m_busy = 0; m_start = 0; m_left = 0;
            m_chan = 0; m_res = 0; p0 = 0; p1 = 0; p2 = 0;
            armed = 1;
        end else begin
            edge_seen = p1 && !p2;
            wr0   = bus_wr && !bus_addr;
            d_eff = wr0 ? (m_done && bus_wdata[4]) : m_done;
            go    = ((wr0 && bus_wdata[3]) || (edge_seen && m_ext_en)) && !m_busy && !d_eff;
            fin   = m_busy && m_left == 1;
            if (wr0 && !m_busy && !m_done) m_chan = bus_wdata[2:0];
            if (wr0) m_ext_en = bus_wdata[5];
            m_done  = fin ? 1'b1 : d_eff;
            m_start = go;
            if (go) begin
                m_busy = 1; m_left = N;
            end else if (fin) begin
                m_busy = 0; m_res = conv_result; m_left = 0;
            end else if (m_busy) m_left--;
            p2 = p1; p1 = p0; p0 = ext_start;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            check({cur_req, " start"}, conv_start, m_start);
            check({cur_req, " chan"}, conv_chan, m_chan);
            check({cur_req, " irq"}, irq, m_done && irq_enable);
            check({cur_req, " rdata"}, bus_rdata,
                  bus_addr ? int'(m_res[9:2]) : int'({m_res[1:0], m_ext_en, m_done, m_busy, m_chan}));
        end
        conv_result <= conv_result * 10'd7 + 10'd123;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bus_wr = 0; bus_addr = ~bus_addr;
        end
    endtask

    task automatic wr(input logic [5:0] v);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = 0; bus_wdata = v;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); #1;
        bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 reshi", v, 0);

        cur_req = "R2";
        wr(6'h0D);                       // channel 5 + start
        rd(0, v); check("R2 busy", v[3], 1);
        cur_req = "R10";
        wr(6'h00);                       // try to clear busy and move channel
        rd(0, v); check("R10 busy kept", v[3], 1);
        check("R9 chan locked busy", conv_chan, 5);
        cur_req = "R6";
        wr(6'h28);                       // restart attempt, trigger enabled
        ext_start = 1; idle(4); ext_start = 0;
        cur_req = "R3";
        idle(N);
        rd(0, v); check("R3 done", v[4:3], 2'b10);
        cur_req = "R4";
        rd(0, v); check("R4 low bits", v[7:6], m_res[1:0]);
        rd(1, v); check("R4 high bits", v, m_res[9:2]);
        cur_req = "R11";
        irq_enable = 1; idle(1); #1 check("R11 irq on", irq, 1);
        irq_enable = 0; idle(1); #1 check("R11 irq off", irq, 0);
        irq_enable = 1;
        cur_req = "R7";
        wr(6'h18);
        idle(2);
        rd(0, v); check("R7 no start", v[3], 0);
        cur_req = "R9";
        wr(6'h13);                       // channel write while done
        rd(0, v); check("R9 chan locked done", v[2:0], 5);
        cur_req = "R8";
        wr(6'h0A);                       // clear done + start, channel ignored
        rd(0, v); check("R8 restarted", v[4:3], 2'b01);
        check("R8 same chan", conv_chan, 5);
        idle(N + 2);
        cur_req = "R10";
        wr(6'h00);                       // clear done
        wr(6'h12);                       // try to set done, channel 2
        rd(0, v); check("R10 done not set", v[4], 0);
        check("R9 chan idle write", conv_chan, 2);
        cur_req = "R12";
        wr(6'h08);
        idle(N - 1);
        wr(6'h00);                       // clear lands on completion edge
        rd(0, v); check("R12 done wins", v[4:3], 2'b10);
        cur_req = "R5";
        wr(6'h00);                       // trigger disabled
        ext_start = 1; idle(5); ext_start = 0; idle(3);
        rd(0, v); check("R5 pin ignored", v[3], 0);
        wr(6'h20);
        ext_start = 1; idle(4);
        rd(0, v); check("R5 pin start", v[3], 1);
        ext_start = 0;
        idle(N + 2);
        wr(6'h28);                       // clear done + start, pin edge at once
        ext_start = 1; idle(4); ext_start = 0;
        idle(N + 4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule